// File: doc/BRIEF.md
# Receive Line Idle Time-out Counter

This block watches a serial receiver for a quiet line. It counts bit periods in which no new character arrives. When a programmed limit runs out, it raises a sticky time-out flag. A once-per-bit-period tick from the baud logic paces it. The receiver sends a one-cycle pulse for every completed character. Software supplies an 8-bit limit and a restart command pulse.

The block does not count until it has seen a first character. Every later character reloads the count. A bit-tick prescaler divides by four, so one unit of the limit equals four bit periods and the total wait is the limit times four bit periods. A limit of zero switches detection off. After the flag is raised the counter stops. The flag stays set until a restart command clears it, and the restart also makes the block wait for a new first character.

Top module: `rx_idle_timer`

## Requirements
- R1: After reset `tmo_flag` is 0 and the block is waiting for a first character, so bit ticks alone cannot set the flag.
- R2: A character pulse seen while `tmo_limit` is 0 does not arm the block, and the flag stays 0 no matter how many bit ticks follow.
- R3: With a nonzero limit, no bit tick has any effect until the first character pulse arrives.
- R4: After a character with limit L (1..255) is accepted, `tmo_flag` rises on the clock edge that registers the (4·L)-th bit tick seen in the later cycles, and not earlier. A tick in the same cycle as the character is not counted.
- R5: While counting, each character pulse reloads the count from `tmo_limit` and clears the prescaler. If a tick arrives in the same cycle as the character, the reload wins and that tick is not counted.
- R6: A change to `tmo_limit` during a count does not change the count in progress. The new value is used at the next reload.
- R7: Once set, `tmo_flag` stays 1, and further ticks and character pulses have no effect until a restart.
- R8: A `tmo_restart` pulse clears `tmo_flag` on the next edge and returns the block to waiting for a first character. A character pulse in the same cycle as the restart is ignored.
- R9: A character pulse while counting with `tmo_limit` equal to 0 stops the count and returns the block to waiting, so the flag does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle pulse once per bit period |
| char_rcvd | input | 1 | One-cycle pulse per received character |
| tmo_limit | input | 8 | Time-out limit in units of four bit periods; 0 disables |
| tmo_restart | input | 1 | One-cycle command: clear the flag and wait for a first character |
| tmo_flag | output | 1 | Sticky time-out status |

## Verification
The embedded assertions check on every cycle that the flag holds, that restart clears it and that it rises only from the counting state. They also check that a zero limit never arms the block, that a reload captures the limit, that the count never rises without a load, and that the prescaler is cleared on every reload. Only the bench scenarios show the exact duration of 4·L ticks, including the full 1020-tick case. The bench scenarios also cover the reload-versus-tick tie in one cycle, a limit changed during a count, and a character ignored when it arrives together with a restart.

// File: rtl/tmo_pkg.sv
package tmo_pkg;

    typedef enum logic [1:0] {
        ST_WAIT    = 2'd0,
        ST_RUN     = 2'd1,
        ST_EXPIRED = 2'd2
    } tmo_state_e;

    typedef struct packed {
        tmo_state_e state;
        logic       flag;
    } tmo_ctrl_t;

endpackage

// File: rtl/tmo_prescaler.sv
module tmo_prescaler #(
    parameter int DIV_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic wrap
);
    localparam logic [DIV_W-1:0] LAST = {DIV_W{1'b1}};

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign wrap = tick && !clear && (cnt_q == LAST);

    // R5: every reload leaves the prescaler at zero
    a_r5_presc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

endmodule

// File: rtl/tmo_downcount.sv
module tmo_downcount #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         hit_zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (load) begin
            cnt_d = load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // last step of a count: a decrement taking one down to zero
    assign hit_zero = dec && !load && !clear && (cnt_q == {{(W-1){1'b0}}, 1'b1});

    // R5, R6: a reload captures the limit present in that cycle
    a_r5_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear) |=> (cnt_q == $past(load_val)));

    // R4: without a load the count never grows
    a_r4_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !clear) |=> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/tmo_ctrl.sv
module tmo_ctrl
    import tmo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic char_rcvd,
    input  logic restart,
    input  logic limit_nz,
    input  logic hit_zero,
    output logic load,
    output logic clear,
    output logic count_en,
    output logic flag
);
    tmo_ctrl_t ctl_d, ctl_q;

    // counting is enabled only in cycles with no reload or restart
    assign count_en = (ctl_q.state == ST_RUN) && !char_rcvd && !restart;

    always_comb begin
        ctl_d = ctl_q;
        load  = 1'b0;
        clear = 1'b0;
        if (restart) begin
            ctl_d.state = ST_WAIT;
            ctl_d.flag  = 1'b0;
            clear       = 1'b1;
        end else begin
            unique case (ctl_q.state)
                ST_WAIT: begin
                    if (char_rcvd && limit_nz) begin
                        load        = 1'b1;
                        ctl_d.state = ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (char_rcvd) begin
                        if (limit_nz) begin
                            load = 1'b1;
                        end else begin
                            clear       = 1'b1;
                            ctl_d.state = ST_WAIT;
                        end
                    end else if (hit_zero) begin
                        ctl_d.state = ST_EXPIRED;
                        ctl_d.flag  = 1'b1;
                    end
                end
                ST_EXPIRED: begin
                    ctl_d = ctl_q;
                end
                default: begin
                    ctl_d.state = ST_WAIT;
                    ctl_d.flag  = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_WAIT, flag: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign flag = ctl_q.flag;

    // R7: flag holds until a restart
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !restart) |=> flag);

    // R8: restart clears the flag and re-arms the wait
    a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!flag && ctl_q.state == ST_WAIT));

    // R2: a zero limit never arms the block
    a_r2_zero_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_WAIT && !limit_nz) |=> (ctl_q.state == ST_WAIT));

    // R4: the flag only rises out of an active count
    a_r4_rise_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(ctl_q.state) == ST_RUN));

endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
    parameter int LIMIT_W = 8,
    parameter int PRE_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_tick,
    input  logic               char_rcvd,
    input  logic [LIMIT_W-1:0] tmo_limit,
    input  logic               tmo_restart,
    output logic               tmo_flag
);
    logic limit_nz;
    logic load, clear, count_en;
    logic wrap, hit_zero;

    assign limit_nz = |tmo_limit;

    tmo_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .char_rcvd(char_rcvd),
        .restart  (tmo_restart),
        .limit_nz (limit_nz),
        .hit_zero (hit_zero),
        .load     (load),
        .clear    (clear),
        .count_en (count_en),
        .flag     (tmo_flag)
    );

    tmo_prescaler #(.DIV_W(PRE_W)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(load || clear),
        .tick (bit_tick && count_en),
        .wrap (wrap)
    );

    tmo_downcount #(.W(LIMIT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .load    (load),
        .load_val(tmo_limit),
        .dec     (wrap),
        .hit_zero(hit_zero)
    );

endmodule

// File: tb/rx_idle_timer_tb.sv
module rx_idle_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       char_rcvd = 1'b0;
    logic [7:0] tmo_limit = 8'd0;
    logic       tmo_restart = 1'b0;
    logic       tmo_flag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    rx_idle_timer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .char_rcvd  (char_rcvd),
        .tmo_limit  (tmo_limit),
        .tmo_restart(tmo_restart),
        .tmo_flag   (tmo_flag)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic exp);
        checks++;
        if (tmo_flag !== exp) begin
            errors++;
            $display("FAIL %s: tmo_flag actual %b expected %b", req, tmo_flag, exp);
        end
    endtask

    // one-cycle pulses, driven and sampled at falling edges
    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic char_pulse(input logic with_tick);
        char_rcvd = 1'b1;
        bit_tick  = with_tick;
        @(negedge clk);
        char_rcvd = 1'b0;
        bit_tick  = 1'b0;
    endtask

    task automatic restart_pulse(input logic with_char);
        tmo_restart = 1'b1;
        char_rcvd   = with_char;
        @(negedge clk);
        tmo_restart = 1'b0;
        char_rcvd   = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset", 1'b0);
        ticks(40);
        chk("R1 ticks after reset", 1'b0);
    endtask

    task automatic t_unarmed();
        tmo_limit = 8'd2;
        ticks(60);
        chk("R3 no first char", 1'b0);
    endtask

    task automatic t_zero();
        tmo_limit = 8'd0;
        char_pulse(1'b0);
        ticks(200);
        chk("R2 zero limit", 1'b0);
    endtask

    task automatic t_duration(input logic [7:0] lim);
        restart_pulse(1'b0);
        tmo_limit = lim;
        char_pulse(1'b1);   // tick alongside the arming char is not counted
        ticks(4 * lim - 1);
        chk("R4 one tick short", 1'b0);
        ticks(1);
        chk("R4 exact expiry", 1'b1);
    endtask

    task automatic t_sticky();
        ticks(30);
        char_pulse(1'b0);
        ticks(10);
        chk("R7 sticky after ticks and chars", 1'b1);
        restart_pulse(1'b0);
        chk("R8 restart clears", 1'b0);
        ticks(30);
        chk("R8 waiting after restart", 1'b0);
    endtask

    task automatic t_reload();
        restart_pulse(1'b0);
        tmo_limit = 8'd2;
        char_pulse(1'b0);
        ticks(7);
        char_pulse(1'b0);
        ticks(7);
        chk("R5 reload restarts count", 1'b0);
        char_pulse(1'b1);   // reload wins over coincident tick
        ticks(7);
        chk("R5 reload beats tick", 1'b0);
        ticks(1);
        chk("R5 expiry after reload", 1'b1);
    endtask

    task automatic t_change();
        restart_pulse(1'b0);
        tmo_limit = 8'd2;
        char_pulse(1'b0);
        tmo_limit = 8'd10;
        ticks(7);
        chk("R6 old limit still counting", 1'b0);
        ticks(1);
        chk("R6 old limit used", 1'b1);
        restart_pulse(1'b0);
        char_pulse(1'b0);
        ticks(39);
        chk("R6 new limit after reload short", 1'b0);
        ticks(1);
        chk("R6 new limit after reload", 1'b1);
    endtask

    task automatic t_zero_reload();
        restart_pulse(1'b0);
        tmo_limit = 8'd2;
        char_pulse(1'b0);
        ticks(4);
        tmo_limit = 8'd0;
        char_pulse(1'b0);
        ticks(100);
        chk("R9 zero reload stops", 1'b0);
        tmo_limit = 8'd1;
        char_pulse(1'b0);
        ticks(4);
        chk("R9 rearm after disable", 1'b1);
    endtask

    task automatic t_restart_char();
        restart_pulse(1'b1);
        chk("R8 restart with char clears", 1'b0);
        ticks(50);
        chk("R8 char with restart ignored", 1'b0);
        tmo_limit = 8'd3;
        char_pulse(1'b0);
        ticks(5);
        restart_pulse(1'b0);
        ticks(40);
        chk("R8 restart mid-count", 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unarmed();
        t_zero();
        t_duration(8'd3);
        t_sticky();
        t_duration(8'd1);
        t_duration(8'd255);
        t_reload();
        t_change();
        t_zero_reload();
        t_restart_char();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule